// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs the bus cycles of an 8-bit asynchronous NAND flash device for a host that requests one whole operation at a time. The host chooses one of six operations: page read, page program, block erase, identifier read, status read or device reset. It supplies a row (page) index and a column, and it connects a byte-wide page buffer port. The block then drives chip enable, the command and address latch enables, the write and read strobes and the I/O bus. It waits on the ready/busy line and guards that wait with a timeout. It ends each operation with a one-cycle done pulse and a set of sticky error flags.

After a program or an erase, the block reads the device status itself and judges the result from the ready and fail bits. The host learns the outcome from the flags and does not poll the device. Page bytes move through the buffer port one at a time. For a program the host returns the byte at the index the block shows. For a read or an identifier read the block writes each byte it receives.

Top module: `nand_seq`

## Requirements
- R1: Page read (op code 0) latches opcode 0x00, five address bytes and opcode 0x30. After ready/busy rises it reads PAGE_BYTES bytes and writes them to buffer indices 0 upward in order.
- R2: Page program (op code 1) latches 0x80 and five address bytes. It then latches PAGE_BYTES data bytes, each taken from buf_rd_byte while buf_idx shows 0 upward, and then 0x10. After ready/busy rises it runs the status poll of R4.
- R3: Block erase (op code 2) latches 0x60, only the three row address bytes (no column bytes) and 0xD0. After ready/busy rises it runs the status poll of R4.
- R4: The status poll latches 0x70 and reads one byte into status_byte. The result passes only when bit 6 is 1 and bit 0 is 0. On any other value the block sets err_flags bit 2 for a program or bit 3 for an erase.
- R5: Identifier read (op code 3) latches 0x90 and one address byte 0x00, and writes the next five bytes read to buffer indices 0 to 4. It does not wait on ready/busy.
- R6: Reset (op code 5) latches 0xFF with no address byte and then waits for ready/busy to rise.
- R7: The five address bytes are: column bits 7:0; then column bits 11:8 in the low nibble with the upper nibble zero; then row bits 7:0, row bits 15:8, and row bit 16 in bit 0 with bits 7:1 zero.
- R8: A ready/busy wait that lasts CLK_HZ/1000*TMO_MS cycles ends the operation at once. A read or reset sets err_flags bit 0. A program or erase sets bit 1 and skips the status poll.
- R9: Error flags stay set across later operations and add up by type. A one-cycle err_clr clears them all.
- R10: CLE is high only while an opcode is latched and ALE only while an address byte is latched. The two are never high together, and CE# is low whenever a strobe is low.
- R11: Every WE# and RE# low phase lasts at least STROBE_LO clocks and every high phase between two strobes at least STROBE_HI clocks. WE# and RE# are never low together.
- R12: Status read (op code 4) latches 0x70, reads one byte into status_byte and changes no error flag.
- R13: A request is taken only when the block is idle and req_op is 0 to 5. Codes 6 and 7, and any request made while busy, have no effect. busy stays high from acceptance through the single done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 3 | Operation code (0 read, 1 program, 2 erase, 3 identifier, 4 status, 5 reset) |
| req_row | input | ROW_W | Row (page) index |
| req_col | input | 12 | Column byte offset |
| err_clr | input | 1 | Clears all error flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_flags | output | 4 | Sticky: read timeout, write timeout, program fail, erase fail (bits 0..3) |
| status_byte | output | 8 | Last status byte read from the device |
| buf_idx | output | IDX_W | Page buffer byte index |
| buf_wr | output | 1 | Page buffer write strobe |
| buf_wr_byte | output | 8 | Byte written to the page buffer |
| buf_rd_byte | input | 8 | Byte read from the page buffer at buf_idx |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus value driven to the device |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus value from the device |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The bench sets PAGE_BYTES to 8 so that each read or program moves the full data phase in a few dozen cycles. It sets CLK_HZ to 20000 and TMO_MS to 5, so the timeout lands after 100 cycles. A responder that holds ready/busy low then reaches both timeout flags quickly. STROBE_LO is 3 and STROBE_HI is 2, which differ from each other and from one. A strobe phase cut short or a swapped phase count therefore shows in the measured widths.

// File: rtl/nand_seq_pkg.sv
// Shared types and device opcodes for the NAND command sequencer.
// Assumes an 8-bit asynchronous NAND device.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_ID     = 3'd3,
        OP_STATUS = 3'd4,
        OP_RESET  = 3'd5
    } nand_op_e;

    typedef enum logic [1:0] {
        XF_CMD   = 2'd0,
        XF_ADDR  = 2'd1,
        XF_WDATA = 2'd2,
        XF_RDATA = 2'd3
    } xfer_kind_e;

    localparam logic [7:0] NC_READ1  = 8'h00;
    localparam logic [7:0] NC_READ2  = 8'h30;
    localparam logic [7:0] NC_PROG1  = 8'h80;
    localparam logic [7:0] NC_PROG2  = 8'h10;
    localparam logic [7:0] NC_ERASE1 = 8'h60;
    localparam logic [7:0] NC_ERASE2 = 8'hD0;
    localparam logic [7:0] NC_ID     = 8'h90;
    localparam logic [7:0] NC_STATUS = 8'h70;
    localparam logic [7:0] NC_RESET  = 8'hFF;

    localparam int ST_READY_BIT = 6;
    localparam int ST_FAIL_BIT  = 0;

    localparam int ERR_RD_TMO = 0;
    localparam int ERR_WR_TMO = 1;
    localparam int ERR_PROG   = 2;
    localparam int ERR_ERASE  = 3;

endpackage

// File: rtl/nand_addr_fmt.sv
// Address byte formatter: turns a 12-bit column and a ROW_W-bit row into
// the five bytes of a full NAND address. Purely combinational.
// Assumes ROW_W <= 24; row bits above ROW_W-1 are zero.
module nand_addr_fmt #(
    parameter int ROW_W = 17
) (
    input  logic [11:0]      col,
    input  logic [ROW_W-1:0] row,
    output logic [4:0][7:0]  abyte
);
    localparam int ROW_PAD = 24;

    logic [ROW_PAD-1:0] row_ext;

    // Zero-extend the row to three whole bytes.
    always_comb begin
        row_ext = '0;
        row_ext[ROW_W-1:0] = row;
    end

    // Place column and row bytes in device order, column first.
    always_comb begin
        abyte[0] = col[7:0];
        abyte[1] = {4'h0, col[11:8]};
        abyte[2] = row_ext[7:0];
        abyte[3] = row_ext[15:8];
        abyte[4] = row_ext[23:16];
    end
endmodule

// File: rtl/nand_bus_phy.sv
// Single bus-cycle engine: runs one opcode, address, write-data or
// read-data cycle with a low strobe phase of LO_CYC clocks and a high
// phase of HI_CYC clocks. Accepts start only when idle; pulses done one
// cycle after the high phase ends. Read data is sampled as RE# rises.
module nand_bus_phy
    import nand_seq_pkg::*;
#(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  xfer_kind_e kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] io_in,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic [7:0] rbyte,
    output logic       done
);
    localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          is_rd;

    // Step through idle, strobe-low and strobe-high phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            is_rd  <= 1'b0;
            we_n   <= 1'b1;
            re_n   <= 1'b1;
            cle    <= 1'b0;
            ale    <= 1'b0;
            io_out <= '0;
            io_oe  <= 1'b0;
            rbyte  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    cle    <= (kind == XF_CMD);
                    ale    <= (kind == XF_ADDR);
                    io_oe  <= (kind != XF_RDATA);
                    io_out <= wbyte;
                    is_rd  <= (kind == XF_RDATA);
                    if (kind == XF_RDATA) re_n <= 1'b0;
                    else                  we_n <= 1'b0;
                    cnt    <= CW'(LO_CYC - 1);
                    ph     <= PH_LO;
                end
                PH_LO: if (cnt == '0) begin
                    we_n <= 1'b1;
                    re_n <= 1'b1;
                    if (is_rd) rbyte <= io_in;
                    cnt  <= CW'(HI_CYC - 1);
                    ph   <= PH_HI;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_HI: if (cnt == '0) begin
                    cle   <= 1'b0;
                    ale   <= 1'b0;
                    io_oe <= 1'b0;
                    done  <= 1'b1;
                    ph    <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R11
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R10
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe); // R10
    AST_LATCH_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cle || ale) |-> re_n); // R10
endmodule

// File: rtl/nand_rb_timer.sv
// Ready/busy watcher: synchronises the ready/busy line, reports a rising
// edge while run is high and flags expiry after TMO_CYC cycles of run.
// The count restarts whenever run is low.
module nand_rb_timer #(
    parameter int TMO_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rb,
    output logic rb_rise,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic          rb_m, rb_s, rb_q;
    logic [TW-1:0] cnt;

    // Two-stage synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_m <= 1'b1;
            rb_s <= 1'b1;
            rb_q <= 1'b1;
        end else begin
            rb_m <= rb;
            rb_s <= rb_m;
            rb_q <= rb_s;
        end
    end

    // Count cycles spent waiting; cleared when not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expired)  cnt <= cnt + 1'b1;
    end

    assign rb_rise = run && rb_s && !rb_q;
    assign expired = run && (cnt == TW'(TMO_CYC - 1));

    AST_TMO_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> run); // R8
    AST_TMO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TW'(TMO_CYC - 1)); // R8
endmodule

// File: rtl/nand_seq.sv
// NAND command sequencer top. Accepts one operation while idle, runs its
// opcode/address/data cycles through nand_bus_phy, waits on ready/busy
// through nand_rb_timer, polls status after program and erase, and ends
// with a one-cycle done pulse. Error flags are sticky until err_clr.
// Assumes PAGE_BYTES >= 8 and ROW_W <= 24.
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int ROW_W      = 17,
    parameter int CLK_HZ     = 50_000_000,
    parameter int TMO_MS     = 100,
    parameter int STROBE_LO  = 2,
    parameter int STROBE_HI  = 2,
    parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [11:0]      req_col,
    input  logic             err_clr,
    output logic             busy,
    output logic             done,
    output logic [3:0]       err_flags,
    output logic [7:0]       status_byte,
    output logic [IDX_W-1:0] buf_idx,
    output logic             buf_wr,
    output logic [7:0]       buf_wr_byte,
    input  logic [7:0]       buf_rd_byte,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb
);
    localparam int TMO_CYC = (CLK_HZ / 1000) * TMO_MS;
    localparam int ID_LAST = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAITRB,
        S_RDATA, S_STCMD, S_STREAD, S_DONE
    } seq_state_e;

    seq_state_e       st;
    nand_op_e         op_q;
    logic [ROW_W-1:0] row_q;
    logic [11:0]      col_q;
    logic [2:0]       aidx;
    logic [IDX_W-1:0] bcnt;
    logic             issued;
    logic [3:0]       err_q;
    logic [3:0]       err_set;
    logic [7:0]       stat_q;

    logic             phy_start, phy_done;
    xfer_kind_e       phy_kind;
    logic [7:0]       phy_wbyte, phy_rbyte;
    logic [4:0][7:0]  abyte;
    logic             rb_rise, tmo;
    logic             bus_state, accept;
    logic [7:0]       cmd1, cmd2;
    logic [2:0]       aidx_last;
    logic [IDX_W-1:0] rd_last;
    logic             st_ok;

    nand_addr_fmt #(.ROW_W(ROW_W)) fmt_i (
        .col   (col_q),
        .row   (row_q),
        .abyte (abyte)
    );

    nand_bus_phy #(.LO_CYC(STROBE_LO), .HI_CYC(STROBE_HI)) phy_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (phy_start),
        .kind   (phy_kind),
        .wbyte  (phy_wbyte),
        .io_in  (nand_io_in),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .io_out (nand_io_out),
        .io_oe  (nand_io_oe),
        .rbyte  (phy_rbyte),
        .done   (phy_done)
    );

    nand_rb_timer #(.TMO_CYC(TMO_CYC)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == S_WAITRB),
        .rb      (nand_rb),
        .rb_rise (rb_rise),
        .expired (tmo)
    );

    // Per-operation opcodes and sequence limits.
    always_comb begin
        cmd1      = NC_RESET;
        cmd2      = NC_READ2;
        aidx_last = 3'd4;
        rd_last   = IDX_W'(PAGE_BYTES - 1);
        case (op_q)
            OP_READ:   begin cmd1 = NC_READ1;  cmd2 = NC_READ2;  end
            OP_PROG:   begin cmd1 = NC_PROG1;  cmd2 = NC_PROG2;  end
            OP_ERASE:  begin cmd1 = NC_ERASE1; cmd2 = NC_ERASE2; end
            OP_ID:     begin cmd1 = NC_ID; aidx_last = 3'd0;
                             rd_last = IDX_W'(ID_LAST); end
            OP_STATUS: cmd1 = NC_STATUS;
            default:   cmd1 = NC_RESET;
        endcase
    end

    // Bus cycle request for the current state.
    always_comb begin
        bus_state = 1'b1;
        phy_kind  = XF_CMD;
        phy_wbyte = 8'h00;
        case (st)
            S_CMD1:   phy_wbyte = cmd1;
            S_ADDR:   begin phy_kind = XF_ADDR;  phy_wbyte = abyte[aidx]; end
            S_WDATA:  begin phy_kind = XF_WDATA; phy_wbyte = buf_rd_byte; end
            S_CMD2:   phy_wbyte = cmd2;
            S_STCMD:  phy_wbyte = NC_STATUS;
            S_RDATA,
            S_STREAD: phy_kind = XF_RDATA;
            default:  bus_state = 1'b0;
        endcase
    end

    assign phy_start = bus_state && !issued;
    assign accept    = (st == S_IDLE) && req_valid && (req_op <= 3'd5);
    assign st_ok     = phy_rbyte[ST_READY_BIT] && !phy_rbyte[ST_FAIL_BIT];

    // Error bits raised by the current cycle.
    always_comb begin
        err_set = '0;
        if (st == S_WAITRB && !rb_rise && tmo) begin
            if (op_q == OP_PROG || op_q == OP_ERASE) err_set[ERR_WR_TMO] = 1'b1;
            else                                     err_set[ERR_RD_TMO] = 1'b1;
        end
        if (st == S_STREAD && phy_done && !st_ok) begin
            if (op_q == OP_PROG)  err_set[ERR_PROG]  = 1'b1;
            if (op_q == OP_ERASE) err_set[ERR_ERASE] = 1'b1;
        end
    end

    // Sticky error flags with host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_clr ? 4'h0 : err_q) | err_set;
    end

    // Track whether the current state's bus cycle has been launched.
    always_ff @(posedge clk) begin
        if (!rst_n)         issued <= 1'b0;
        else if (phy_done)  issued <= 1'b0;
        else if (phy_start) issued <= 1'b1;
    end

    // Main operation sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            op_q   <= OP_READ;
            row_q  <= '0;
            col_q  <= '0;
            aidx   <= '0;
            bcnt   <= '0;
            stat_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (accept) begin
                    op_q  <= nand_op_e'(req_op);
                    row_q <= (req_op == OP_ID) ? '0 : req_row;
                    col_q <= (req_op == OP_ID) ? '0 : req_col;
                    st    <= S_CMD1;
                end
                S_CMD1: if (phy_done) begin
                    aidx <= (op_q == OP_ERASE) ? 3'd2 : 3'd0;
                    bcnt <= '0;
                    if (op_q == OP_RESET)       st <= S_WAITRB;
                    else if (op_q == OP_STATUS) st <= S_STREAD;
                    else                        st <= S_ADDR;
                end
                S_ADDR: if (phy_done) begin
                    if (aidx == aidx_last) begin
                        if (op_q == OP_PROG)    st <= S_WDATA;
                        else if (op_q == OP_ID) st <= S_RDATA;
                        else                    st <= S_CMD2;
                    end else begin
                        aidx <= aidx + 1'b1;
                    end
                end
                S_WDATA: if (phy_done) begin
                    if (bcnt == IDX_W'(PAGE_BYTES - 1)) st <= S_CMD2;
                    else                                bcnt <= bcnt + 1'b1;
                end
                S_CMD2: if (phy_done) st <= S_WAITRB;
                S_WAITRB: begin
                    bcnt <= '0;
                    if (rb_rise) begin
                        if (op_q == OP_READ)       st <= S_RDATA;
                        else if (op_q == OP_RESET) st <= S_DONE;
                        else                       st <= S_STCMD;
                    end else if (tmo) begin
                        st <= S_DONE;
                    end
                end
                S_RDATA: if (phy_done) begin
                    if (bcnt == rd_last) st <= S_DONE;
                    else                 bcnt <= bcnt + 1'b1;
                end
                S_STCMD: if (phy_done) st <= S_STREAD;
                S_STREAD: if (phy_done) begin
                    stat_q <= phy_rbyte;
                    st     <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy        = (st != S_IDLE);
    assign done        = (st == S_DONE);
    assign nand_ce_n   = (st == S_IDLE);
    assign err_flags   = err_q;
    assign status_byte = stat_q;
    assign buf_idx     = bcnt;
    assign buf_wr      = (st == S_RDATA) && phy_done;
    assign buf_wr_byte = phy_rbyte;

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R13
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R9
    AST_CE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R10
    AST_BUS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale)); // R13
endmodule

// File: tb/nand_seq_tb_top.sv
module nand_seq_tb_top;
    localparam int PB    = 8;
    localparam int SLO   = 3;
    localparam int SHI   = 2;
    localparam int BUSYC = 20;
    localparam int IW    = $clog2(PB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [16:0]   req_row = '0;
    logic [11:0]   req_col = '0;
    logic          err_clr = 1'b0;
    logic          busy, done, buf_wr;
    logic [3:0]    err_flags;
    logic [7:0]    status_byte, buf_wr_byte, buf_rd_byte;
    logic [IW-1:0] buf_idx;
    logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]    nand_io_out;
    logic [7:0]    nand_io_in = '0;
    logic          nand_rb = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nand_seq #(.PAGE_BYTES(PB), .ROW_W(17), .CLK_HZ(20000), .TMO_MS(5),
               .STROBE_LO(SLO), .STROBE_HI(SHI)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_row(req_row), .req_col(req_col), .err_clr(err_clr),
        .busy(busy), .done(done), .err_flags(err_flags), .status_byte(status_byte),
        .buf_idx(buf_idx), .buf_wr(buf_wr), .buf_wr_byte(buf_wr_byte),
        .buf_rd_byte(buf_rd_byte), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    // Host-side page buffer model.
    logic [7:0] wrmem [PB];
    logic [7:0] rdmem [PB];
    assign buf_rd_byte = wrmem[buf_idx];
    always @(posedge clk) if (buf_wr) rdmem[buf_idx] <= buf_wr_byte;

    // Device responder state.
    logic [7:0] stat_ret = 8'h40;
    logic [7:0] rd_seed  = 8'h00;
    bit         stuck    = 1'b0;
    int         rd_mode  = 0;
    int         rd_k     = 0;
    int         busy_evt = 0;
    int         busy_seen = 0;
    int         busy_left = 0;
    logic [7:0] lg_byte [64];
    logic [1:0] lg_kind [64];
    int         lg_n = 0;

    // Record latched bytes and react to opcodes.
    always @(posedge nand_we_n) begin
        if (rst_n && !nand_ce_n) begin
            if (lg_n < 64) begin
                lg_byte[lg_n] = nand_io_out;
                lg_kind[lg_n] = {nand_cle, nand_ale};
            end
            lg_n++;
            if (nand_cle) begin
                case (nand_io_out)
                    8'h90: begin rd_mode = 1; rd_k = 0; end
                    8'h70: rd_mode = 2;
                    8'h30: begin rd_mode = 0; rd_k = 0; busy_evt++; end
                    8'h10, 8'hD0, 8'hFF: busy_evt++;
                    default: ;
                endcase
            end
        end
    end

    // Return read data on each RE# fall.
    always @(negedge nand_re_n) begin
        if (rst_n) begin
            case (rd_mode)
                0: nand_io_in = rd_seed + 8'(rd_k);
                1: nand_io_in = 8'h5A + 8'(8'h11 * rd_k);
                default: nand_io_in = stat_ret;
            endcase
            rd_k++;
        end
    end

    // Ready/busy model.
    always @(negedge clk) begin
        if (busy_seen != busy_evt) begin
            busy_seen = busy_evt;
            nand_rb = 1'b0;
            busy_left = BUSYC;
        end else if (!nand_rb && !stuck) begin
            if (busy_left == 0) nand_rb = 1'b1;
            else busy_left--;
        end
    end

    // Strobe phase width monitor.
    int we_run = 0, re_run = 0;
    logic we_p = 1'b1, re_p = 1'b1;
    int min_lo = 999, min_hi = 999;
    always @(posedge clk) begin
        if (rst_n) begin
            if (nand_we_n == we_p) we_run++;
            else begin
                if (!we_p) min_lo = (we_run < min_lo) ? we_run : min_lo;
                else if (!nand_ce_n && we_run < min_hi) min_hi = we_run;
                we_run = 1;
            end
            if (nand_re_n == re_p) re_run++;
            else begin
                if (!re_p) min_lo = (re_run < min_lo) ? re_run : min_lo;
                else if (!nand_ce_n && re_run < min_hi) min_hi = re_run;
                re_run = 1;
            end
            we_p = nand_we_n;
            re_p = nand_re_n;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [16:0] row,
                         input logic [11:0] col);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_row = row; req_col = col;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Expected bus log built from the requirements.
    logic [7:0] ex_byte [64];
    logic [1:0] ex_kind [64];
    int ex_n;
    function automatic void ex_add(input logic [1:0] k, input logic [7:0] b);
        ex_byte[ex_n] = b; ex_kind[ex_n] = k; ex_n++;
    endfunction
    function automatic void build_exp(input int op, input logic [16:0] row,
                                      input logic [11:0] col, input bit stk);
        logic [7:0] ab [5];
        ab[0] = col[7:0]; ab[1] = {4'h0, col[11:8]};
        ab[2] = row[7:0]; ab[3] = row[15:8]; ab[4] = {7'h0, row[16]};
        ex_n = 0;
        case (op)
            0: begin ex_add(2'b10, 8'h00); for (int i = 0; i < 5; i++) ex_add(2'b01, ab[i]);
                     ex_add(2'b10, 8'h30); end
            1: begin ex_add(2'b10, 8'h80); for (int i = 0; i < 5; i++) ex_add(2'b01, ab[i]);
                     for (int i = 0; i < PB; i++) ex_add(2'b00, wrmem[i]);
                     ex_add(2'b10, 8'h10); if (!stk) ex_add(2'b10, 8'h70); end
            2: begin ex_add(2'b10, 8'h60); for (int i = 2; i < 5; i++) ex_add(2'b01, ab[i]);
                     ex_add(2'b10, 8'hD0); if (!stk) ex_add(2'b10, 8'h70); end
            3: begin ex_add(2'b10, 8'h90); ex_add(2'b01, 8'h00); end
            4: ex_add(2'b10, 8'h70);
            default: ex_add(2'b10, 8'hFF);
        endcase
    endfunction

    function automatic bit log_match();
        if (lg_n != ex_n) return 1'b0;
        for (int i = 0; i < ex_n; i++)
            if (lg_byte[i] !== ex_byte[i] || lg_kind[i] !== ex_kind[i]) return 1'b0;
        return 1'b1;
    endfunction

    // Vector: op(3) row(17) col(12) status(8) stuck(1) exp_err(4) seed(8)
    localparam int NV = 11;
    localparam logic [52:0] VECS [NV] = '{
        {3'd0, 17'h1ABCD, 12'h000, 8'h40, 1'b0, 4'h0, 8'h10},
        {3'd0, 17'h00042, 12'h9F3, 8'h40, 1'b0, 4'h0, 8'hC3},
        {3'd1, 17'h12345, 12'h000, 8'h40, 1'b0, 4'h0, 8'h00},
        {3'd1, 17'h00007, 12'h5A1, 8'h41, 1'b0, 4'h4, 8'h00},
        {3'd2, 17'h1F0C0, 12'h000, 8'hE0, 1'b0, 4'h0, 8'h00},
        {3'd2, 17'h00100, 12'h000, 8'h00, 1'b0, 4'h8, 8'h00},
        {3'd3, 17'h0FFFF, 12'hABC, 8'h40, 1'b0, 4'h0, 8'h00},
        {3'd4, 17'h00000, 12'h000, 8'hC1, 1'b0, 4'h0, 8'h00},
        {3'd5, 17'h00000, 12'h000, 8'h40, 1'b0, 4'h0, 8'h00},
        {3'd2, 17'h0A5A5, 12'h000, 8'h40, 1'b1, 4'h2, 8'h00},
        {3'd0, 17'h13579, 12'h123, 8'h40, 1'b1, 4'h1, 8'h00}
    };

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ok;
        for (int i = 0; i < PB; i++) wrmem[i] = 8'h3C ^ 8'(i * 29);
        repeat (3) @(negedge clk);
        chk(!busy && !done && nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale
            && err_flags == 4'h0, "R13", "reset state", {busy, nand_ce_n, err_flags}, 5'b01000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [2:0] op;  logic [16:0] row; logic [11:0] col;
            logic [7:0] st;  bit stk; logic [3:0] eerr; logic [7:0] seed;
            {op, row, col, st, stk, eerr, seed} = VECS[v];
            stat_ret = st; stuck = stk; rd_seed = seed;
            clear_err();
            lg_n = 0;
            issue(op, row, col);
            wait_done(ok);
            chk(ok, "R13", $sformatf("vec %0d done seen", v), ok, 1);
            chk(err_flags == eerr, (eerr[1:0] != 0) ? "R8" : "R4",
                $sformatf("vec %0d err_flags", v), err_flags, eerr);
            build_exp(op, row, col, stk);
            chk(log_match(), (op == 2) ? "R3 R7" : (op == 1) ? "R2 R7" :
                (op == 3) ? "R5" : (op == 4) ? "R12" : (op == 5) ? "R6" : "R1 R7",
                $sformatf("vec %0d bus log count", v), lg_n, ex_n);
            if (op == 0 && !stk)
                for (int i = 0; i < PB; i++)
                    chk(rdmem[i] == seed + 8'(i), "R1", $sformatf("vec %0d byte %0d", v, i),
                        rdmem[i], seed + 8'(i));
            if (op == 3)
                for (int i = 0; i < 5; i++)
                    chk(rdmem[i] == 8'h5A + 8'(8'h11 * i), "R5", $sformatf("id byte %0d", i),
                        rdmem[i], 8'h5A + 8'(8'h11 * i));
            if ((op == 1 || op == 2 || op == 4) && !stk)
                chk(status_byte == st, (op == 4) ? "R12" : "R4", "status_byte", status_byte, st);
            @(negedge clk);
            chk(!busy, "R13", "busy drops after done", busy, 0);
            if (stk) begin stuck = 1'b0; repeat (BUSYC + 5) @(negedge clk); end
        end

        // Sticky accumulation (R9).
        clear_err();
        stat_ret = 8'h41; issue(3'd1, 17'h1, 12'h0); wait_done(ok);
        stat_ret = 8'h00; issue(3'd2, 17'h2, 12'h0); wait_done(ok);
        stat_ret = 8'h40; issue(3'd4, 17'h0, 12'h0); wait_done(ok);
        chk(err_flags == 4'hC, "R9", "flags accumulate", err_flags, 4'hC);
        stuck = 1'b1; issue(3'd5, 17'h0, 12'h0); wait_done(ok);
        chk(err_flags == 4'hD, "R9 R8", "reset timeout adds bit0", err_flags, 4'hD);
        stuck = 1'b0; repeat (BUSYC + 5) @(negedge clk);
        clear_err();
        chk(err_flags == 4'h0, "R9", "clear", err_flags, 4'h0);

        // Invalid op codes are ignored (R13).
        lg_n = 0;
        issue(3'd6, 17'h0, 12'h0);
        @(negedge clk);
        chk(!busy && lg_n == 0, "R13", "op 6 ignored", busy, 0);
        issue(3'd7, 17'h0, 12'h0);
        @(negedge clk);
        chk(!busy && lg_n == 0, "R13", "op 7 ignored", busy, 0);

        // Request while busy is ignored (R13).
        lg_n = 0; rd_seed = 8'h77;
        issue(3'd0, 17'h00ABC, 12'h004);
        repeat (10) @(negedge clk);
        issue(3'd5, 17'h0, 12'h0);
        wait_done(ok);
        build_exp(0, 17'h00ABC, 12'h004, 1'b0);
        chk(log_match(), "R13", "busy request ignored, log count", lg_n, ex_n);
        @(negedge clk);
        chk(!busy, "R13", "idle after single done", busy, 0);

        // Strobe widths and exclusivity (R10, R11).
        chk(min_lo >= SLO, "R11", "min strobe low width", min_lo, SLO);
        chk(min_hi >= SHI, "R11", "min strobe high width", min_hi, SHI);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule